// File: doc/BRIEF.md
# Capability Fault Trap-Value Reporter

This block sits on the trap-commit side of a processor core that supports capability-checked memory. For each synchronous exception it receives a fault descriptor: the access kind, a normal page fault flag, a load page-table capability fault (in plain and tag-dependent forms), a store/AMO page-table capability fault, a general capability fault with its code, and any other exception with its cause. It also receives the faulting address and the privilege level the trap has been delegated to. It resolves these by priority into one cause code and one secondary trap value, and writes them on the commit strobe.

Page-table capability faults have no cause codes of their own. They reuse the ordinary load and store/AMO page fault codes, and they are told apart by a non-zero secondary trap value (tval2). tval2 is zero for every exception that is neither a capability fault nor a page-table capability fault. There are three register pairs: machine, supervisor (HS/S) and virtual supervisor (VS). The supervisor and virtual-supervisor tval2 registers can also be read through a CSR read port.

Top module: `cap_fault_tval`

## Requirements
- R1: After reset, every trap-value register, every secondary trap-value register and the cause output are zero.
- R2: A load access (access kind 2'b01) with a load page-table capability fault reports cause 13, and tval2 has bit 1 set.
- R3: A store/AMO access (access kind 2'b10 or 2'b11) with a store page-table capability fault reports cause 15, and tval2 has bit 2 set. A store page-table fault flag on a non-store access is ignored, and so is a load page-table fault flag on a non-load access.
- R4: A normal page fault on its own reports cause 12 for fetch (access kind 2'b00), 13 for load and 15 for store, with tval2 zero. When it occurs together with a page-table capability fault, tval2 bit 0 is set alongside that fault's bit.
- R5: A capability fault reports cause 28. Its tval2 has bit 3 set and the 4-bit fault code in bits 7:4. It takes priority over every page fault.
- R6: Any other exception (other-valid asserted) takes priority over everything else. It reports its own 6-bit cause, with tval2 zero.
- R7: A tag-dependent load page-table fault has the lowest priority. It is reported (cause 13, tval2 = 2) only when no other fault is present. Otherwise it leaves no trace in tval2.
- R8: Target mode 2'b11 writes the machine pair, 2'b01 the supervisor pair and 2'b10 the virtual-supervisor pair. tval receives the faulting address, and the other pairs keep their values.
- R9: Registers change only at a clock edge where the commit strobe is high, an exception resolves and the target mode is not 2'b00.
- R10: A CSR read at address 0x14b returns the supervisor tval2, and a read at 0x24b returns the virtual-supervisor tval2, each with hit high. Any other address returns zero with hit low.
- R11: The cause output holds the cause of the last committed exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_commit | input | 1 | Trap-commit strobe |
| tgt_mode | input | 2 | Delegated target: 11 M, 01 HS/S, 10 VS, 00 none |
| acc_kind | input | 2 | 00 fetch, 01 load, 1x store/AMO |
| pg_fault | input | 1 | Normal page fault |
| pte_ld_fault | input | 1 | Load page-table capability fault (not tag-dependent) |
| pte_ld_tagdep | input | 1 | Tag-dependent load page-table capability fault |
| pte_st_fault | input | 1 | Store/AMO page-table capability fault |
| cap_fault | input | 1 | Other capability fault |
| cap_code | input | 4 | Capability fault code |
| oth_vld | input | 1 | Other exception present |
| oth_cause | input | 6 | Cause of the other exception |
| fault_addr | input | XLEN | Faulting address |
| trap_cause | output | 6 | Last committed cause |
| mtval | output | XLEN | Machine trap value |
| mtval2 | output | XLEN | Machine secondary trap value |
| stval | output | XLEN | Supervisor trap value |
| stval2 | output | XLEN | Supervisor secondary trap value |
| vstval | output | XLEN | Virtual-supervisor trap value |
| vstval2 | output | XLEN | Virtual-supervisor secondary trap value |
| csr_raddr | input | 12 | CSR read address |
| csr_rdata | output | XLEN | CSR read data |
| csr_hit | output | 1 | Read address matched |

## Verification
The bench commits a plain page fault alone and expects tval2 to stay zero, which a design that always sets the normal-fault bit would violate. It commits a tag-dependent load fault together with a page fault or a capability fault and expects it to vanish, which catches a design that reports it or merges its bit. It raises mismatched access and fault flags, a commit with no target mode, and fault inputs with no strobe, and expects all registers to stay unchanged. It routes traps to each mode and checks that the other pairs hold their values and that only the two tval2 addresses hit.

// File: rtl/cap_fault_tval_pkg.sv
package cap_fault_tval_pkg;
  localparam int CAUSE_W = 6;
  localparam int T2_W    = 8;
  localparam int NBANK   = 3;

  localparam logic [CAUSE_W-1:0] CAUSE_IPF = 6'd12;
  localparam logic [CAUSE_W-1:0] CAUSE_LPF = 6'd13;
  localparam logic [CAUSE_W-1:0] CAUSE_SPF = 6'd15;

  typedef enum logic [1:0] {
    TM_NONE = 2'b00,
    TM_S    = 2'b01,
    TM_VS   = 2'b10,
    TM_M    = 2'b11
  } tgt_mode_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_ST0   = 2'b10,
    ACC_ST1   = 2'b11
  } acc_kind_e;

  // bank index per mode
  localparam int BK_M  = 0;
  localparam int BK_S  = 1;
  localparam int BK_VS = 2;

  typedef struct packed {
    logic               vld;
    logic [CAUSE_W-1:0] cause;
    logic [T2_W-1:0]    t2;
  } trap_rec_t;
endpackage

// File: rtl/cap_fault_tval_resolve.sv
module cap_fault_tval_resolve
  import cap_fault_tval_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] CAP_CAUSE = 6'd28
) (
  input  logic [1:0]         acc_kind,
  input  logic               pg_fault,
  input  logic               pte_ld_fault,
  input  logic               pte_ld_tagdep,
  input  logic               pte_st_fault,
  input  logic               cap_fault,
  input  logic [3:0]         cap_code,
  input  logic               oth_vld,
  input  logic [CAUSE_W-1:0] oth_cause,
  output trap_rec_t          rec
);
  logic is_ld, is_st, is_if;
  logic ld_pte, st_pte, pg_grp, higher, gated;

  always_comb begin
    is_if  = (acc_kind == ACC_FETCH);
    is_ld  = (acc_kind == ACC_LOAD);
    is_st  = acc_kind[1];
    ld_pte = is_ld & pte_ld_fault;
    st_pte = is_st & pte_st_fault;
    pg_grp = pg_fault | ld_pte | st_pte;
    higher = oth_vld | cap_fault | pg_grp;
    gated  = is_ld & pte_ld_tagdep & ~higher;
  end

  always_comb begin
    rec = '0;
    if (oth_vld) begin
      rec.vld   = 1'b1;
      rec.cause = oth_cause;
    end else if (cap_fault) begin
      rec.vld   = 1'b1;
      rec.cause = CAP_CAUSE;
      rec.t2    = {cap_code, 1'b1, 3'b000};
    end else if (pg_grp) begin
      rec.vld   = 1'b1;
      rec.cause = is_if ? CAUSE_IPF : (is_ld ? CAUSE_LPF : CAUSE_SPF);
      rec.t2    = {5'b00000, st_pte, ld_pte, pg_fault & (ld_pte | st_pte)};
    end else if (gated) begin
      rec.vld   = 1'b1;
      rec.cause = CAUSE_LPF;
      rec.t2    = 8'b0000_0010;
    end
  end
endmodule

// File: rtl/cap_fault_tval_bank.sv
module cap_fault_tval_bank #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] tval_in,
  input  logic [XLEN-1:0] tval2_in,
  output logic [XLEN-1:0] tval_q,
  output logic [XLEN-1:0] tval2_q
);
  logic [XLEN-1:0] tval_d, tval2_d;

  always_comb begin
    tval_d  = tval_q;
    tval2_d = tval2_q;
    if (wr_en) begin
      tval_d  = tval_in;
      tval2_d = tval2_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tval_q  <= '0;
      tval2_q <= '0;
    end else if (wr_en) begin
      tval_q  <= tval_d;
      tval2_q <= tval2_d;
    end
  end

  // R9: a bank not written holds its contents
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(tval_q) && $stable(tval2_q)));

  // R8: a written bank captures the faulting address
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tval_q == $past(tval_in)));
endmodule

// File: rtl/cap_fault_tval_csr_rd.sv
module cap_fault_tval_csr_rd #(
  parameter int          XLEN     = 64,
  parameter logic [11:0] S_ADDR   = 12'h14b,
  parameter logic [11:0] VS_ADDR  = 12'h24b
) (
  input  logic [11:0]     raddr,
  input  logic [XLEN-1:0] s_t2,
  input  logic [XLEN-1:0] vs_t2,
  output logic [XLEN-1:0] rdata,
  output logic            hit
);
  always_comb begin
    rdata = '0;
    hit   = 1'b0;
    if (raddr == S_ADDR) begin
      rdata = s_t2;
      hit   = 1'b1;
    end else if (raddr == VS_ADDR) begin
      rdata = vs_t2;
      hit   = 1'b1;
    end
  end
endmodule

// File: rtl/cap_fault_tval.sv
module cap_fault_tval
  import cap_fault_tval_pkg::*;
#(
  parameter int                 XLEN      = 64,
  parameter logic [CAUSE_W-1:0] CAP_CAUSE = 6'd28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_commit,
  input  logic [1:0]         tgt_mode,
  input  logic [1:0]         acc_kind,
  input  logic               pg_fault,
  input  logic               pte_ld_fault,
  input  logic               pte_ld_tagdep,
  input  logic               pte_st_fault,
  input  logic               cap_fault,
  input  logic [3:0]         cap_code,
  input  logic               oth_vld,
  input  logic [5:0]         oth_cause,
  input  logic [XLEN-1:0]    fault_addr,
  output logic [5:0]         trap_cause,
  output logic [XLEN-1:0]    mtval,
  output logic [XLEN-1:0]    mtval2,
  output logic [XLEN-1:0]    stval,
  output logic [XLEN-1:0]    stval2,
  output logic [XLEN-1:0]    vstval,
  output logic [XLEN-1:0]    vstval2,
  input  logic [11:0]        csr_raddr,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               csr_hit
);
  localparam int PAD_W = XLEN - T2_W;

  trap_rec_t        rec;
  logic [NBANK-1:0] wr_vec;
  logic             commit_ok;
  logic [XLEN-1:0]  t2_full;
  logic [XLEN-1:0]  tval_q  [NBANK];
  logic [XLEN-1:0]  tval2_q [NBANK];
  logic [5:0]       cause_d, cause_q;

  cap_fault_tval_resolve #(.CAP_CAUSE(CAP_CAUSE)) u_res (
    .acc_kind      (acc_kind),
    .pg_fault      (pg_fault),
    .pte_ld_fault  (pte_ld_fault),
    .pte_ld_tagdep (pte_ld_tagdep),
    .pte_st_fault  (pte_st_fault),
    .cap_fault     (cap_fault),
    .cap_code      (cap_code),
    .oth_vld       (oth_vld),
    .oth_cause     (oth_cause),
    .rec           (rec)
  );

  always_comb begin
    commit_ok = trap_commit & rec.vld & (tgt_mode != TM_NONE);
    wr_vec    = '0;
    if (commit_ok) begin
      case (tgt_mode_e'(tgt_mode))
        TM_M:    wr_vec[BK_M]  = 1'b1;
        TM_S:    wr_vec[BK_S]  = 1'b1;
        TM_VS:   wr_vec[BK_VS] = 1'b1;
        default: wr_vec        = '0;
      endcase
    end
    t2_full = {{PAD_W{1'b0}}, rec.t2};
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    cap_fault_tval_bank #(.XLEN(XLEN)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_vec[g]),
      .tval_in  (fault_addr),
      .tval2_in (t2_full),
      .tval_q   (tval_q[g]),
      .tval2_q  (tval2_q[g])
    );
  end

  always_comb begin
    cause_d = cause_q;
    if (commit_ok) cause_d = rec.cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else if (commit_ok) cause_q <= cause_d;
  end

  assign trap_cause = cause_q;
  assign mtval      = tval_q[BK_M];
  assign mtval2     = tval2_q[BK_M];
  assign stval      = tval_q[BK_S];
  assign stval2     = tval2_q[BK_S];
  assign vstval     = tval_q[BK_VS];
  assign vstval2    = tval2_q[BK_VS];

  cap_fault_tval_csr_rd #(.XLEN(XLEN)) u_rd (
    .raddr (csr_raddr),
    .s_t2  (tval2_q[BK_S]),
    .vs_t2 (tval2_q[BK_VS]),
    .rdata (csr_rdata),
    .hit   (csr_hit)
  );

  // R8: at most one bank written per commit
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  // R4: a non-zero tval2 only accompanies a page fault or capability cause
  p_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rec.vld && rec.t2 != '0) |->
      (rec.cause == CAUSE_LPF || rec.cause == CAUSE_SPF || rec.cause == CAP_CAUSE));

  // R6: other exceptions carry their own cause and zero tval2
  p_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oth_vld |-> (rec.vld && rec.t2 == '0 && rec.cause == oth_cause));

  // R7: a tag-dependent load fault leaves no mark when another fault applies
  p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pte_ld_tagdep && !pte_ld_fault && (pg_fault || cap_fault || oth_vld)) |->
      !rec.t2[1]);

  // R11: cause register follows the committed cause
  p_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |=> (trap_cause == $past(rec.cause)));

  // R9: no write without the commit strobe
  p_nocommit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_commit |=> $stable(trap_cause));
endmodule

// File: tb/cap_fault_tval_test.sv
module cap_fault_tval_test;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            trap_commit;
  logic [1:0]      tgt_mode, acc_kind;
  logic            pg_fault, pte_ld_fault, pte_ld_tagdep, pte_st_fault;
  logic            cap_fault, oth_vld;
  logic [3:0]      cap_code;
  logic [5:0]      oth_cause;
  logic [XLEN-1:0] fault_addr;
  logic [5:0]      trap_cause;
  logic [XLEN-1:0] mtval, mtval2, stval, stval2, vstval, vstval2, csr_rdata;
  logic [11:0]     csr_raddr;
  logic            csr_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cap_fault_tval #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .trap_commit(trap_commit), .tgt_mode(tgt_mode),
    .acc_kind(acc_kind), .pg_fault(pg_fault), .pte_ld_fault(pte_ld_fault),
    .pte_ld_tagdep(pte_ld_tagdep), .pte_st_fault(pte_st_fault),
    .cap_fault(cap_fault), .cap_code(cap_code), .oth_vld(oth_vld),
    .oth_cause(oth_cause), .fault_addr(fault_addr), .trap_cause(trap_cause),
    .mtval(mtval), .mtval2(mtval2), .stval(stval), .stval2(stval2),
    .vstval(vstval), .vstval2(vstval2), .csr_raddr(csr_raddr),
    .csr_rdata(csr_rdata), .csr_hit(csr_hit)
  );

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_in();
    trap_commit = 0; tgt_mode = 2'b00; acc_kind = 2'b00;
    pg_fault = 0; pte_ld_fault = 0; pte_ld_tagdep = 0; pte_st_fault = 0;
    cap_fault = 0; cap_code = 4'h0; oth_vld = 0; oth_cause = 6'd0;
    fault_addr = '0; csr_raddr = 12'h000;
  endtask

  // inputs already set by caller; pulse commit over one edge
  task automatic commit_one(logic [1:0] mode, logic [XLEN-1:0] addr);
    @(negedge clk);
    tgt_mode = mode; fault_addr = addr; trap_commit = 1'b1;
    @(negedge clk);
    clr_in();
  endtask

  task automatic t_reset();
    chk("R1 cause", {58'd0, trap_cause}, 0);
    chk("R1 mtval", mtval, 0);   chk("R1 mtval2", mtval2, 0);
    chk("R1 stval2", stval2, 0); chk("R1 vstval", vstval, 0);
    chk("R1 vstval2", vstval2, 0);
  endtask

  task automatic t_ld_pte();
    acc_kind = 2'b01; pte_ld_fault = 1;
    commit_one(2'b01, 64'h1000);
    chk("R2 cause", {58'd0, trap_cause}, 13);
    chk("R2 stval2", stval2, 2);
    chk("R8 stval", stval, 64'h1000);
    csr_raddr = 12'h14b; #1;
    chk("R10 rd 14b", csr_rdata, 2);
    chk("R10 hit 14b", {63'd0, csr_hit}, 1);
    chk("R8 mtval untouched", mtval, 0);
  endtask

  task automatic t_st_pte();
    acc_kind = 2'b10; pte_st_fault = 1;
    commit_one(2'b10, 64'h2000);
    chk("R3 cause", {58'd0, trap_cause}, 15);
    chk("R3 vstval2", vstval2, 4);
    chk("R8 vstval", vstval, 64'h2000);
    chk("R8 stval2 kept", stval2, 2);
    csr_raddr = 12'h24b; #1;
    chk("R10 rd 24b", csr_rdata, 4);
    // mismatched flags: nothing resolves, nothing changes
    acc_kind = 2'b01; pte_st_fault = 1;
    commit_one(2'b10, 64'h3000);
    acc_kind = 2'b11; pte_ld_fault = 1;
    commit_one(2'b10, 64'h3000);
    chk("R3 ignored vstval", vstval, 64'h2000);
    chk("R3 ignored vstval2", vstval2, 4);
    chk("R3 ignored cause", {58'd0, trap_cause}, 15);
  endtask

  task automatic t_pf();
    acc_kind = 2'b01; pg_fault = 1;
    commit_one(2'b11, 64'h4000);
    chk("R4 ld pf cause", {58'd0, trap_cause}, 13);
    chk("R4 ld pf mtval2 zero", mtval2, 0);
    chk("R8 mtval", mtval, 64'h4000);
    acc_kind = 2'b00; pg_fault = 1; pte_ld_fault = 1;
    commit_one(2'b11, 64'h4004);
    chk("R4 if pf cause", {58'd0, trap_cause}, 12);
    chk("R4 if pf mtval2", mtval2, 0);
    acc_kind = 2'b11; pg_fault = 1; pte_st_fault = 1;
    commit_one(2'b01, 64'h5000);
    chk("R4 combo cause", {58'd0, trap_cause}, 15);
    chk("R4 combo stval2", stval2, 5);
  endtask

  task automatic t_cap();
    acc_kind = 2'b01; pg_fault = 1; pte_ld_fault = 1; cap_fault = 1; cap_code = 4'h5;
    commit_one(2'b11, 64'h6000);
    chk("R5 cause", {58'd0, trap_cause}, 28);
    chk("R5 mtval2", mtval2, 64'h58);
  endtask

  task automatic t_other();
    acc_kind = 2'b01; pte_ld_fault = 1; cap_fault = 1; cap_code = 4'hf;
    oth_vld = 1; oth_cause = 6'd4;
    commit_one(2'b01, 64'h7000);
    chk("R6 cause", {58'd0, trap_cause}, 4);
    chk("R6 stval2", stval2, 0);
  endtask

  task automatic t_gated();
    acc_kind = 2'b01; pte_ld_tagdep = 1;
    commit_one(2'b10, 64'h8000);
    chk("R7 alone cause", {58'd0, trap_cause}, 13);
    chk("R7 alone vstval2", vstval2, 2);
    acc_kind = 2'b01; pte_ld_tagdep = 1; pg_fault = 1;
    commit_one(2'b10, 64'h8008);
    chk("R7 with pf vstval2", vstval2, 0);
    acc_kind = 2'b01; pte_ld_tagdep = 1; cap_fault = 1; cap_code = 4'h2;
    commit_one(2'b10, 64'h8010);
    chk("R7 with cap cause", {58'd0, trap_cause}, 28);
    chk("R7 with cap vstval2", vstval2, 64'h28);
  endtask

  task automatic t_nocommit();
    @(negedge clk);
    acc_kind = 2'b10; pte_st_fault = 1; tgt_mode = 2'b01; fault_addr = 64'h9000;
    @(negedge clk); @(negedge clk);
    clr_in();
    chk("R9 no strobe stval", stval, 64'h7000);
    chk("R9 no strobe cause", {58'd0, trap_cause}, 28);
    acc_kind = 2'b10; pte_st_fault = 1;
    commit_one(2'b00, 64'h9100);
    chk("R9 mode none mtval", mtval, 64'h6000);
    chk("R9 mode none stval2", stval2, 0);
    chk("R11 cause kept", {58'd0, trap_cause}, 28);
  endtask

  task automatic t_csr_miss();
    csr_raddr = 12'h143; #1;
    chk("R10 miss data", csr_rdata, 0);
    chk("R10 miss hit", {63'd0, csr_hit}, 0);
    csr_raddr = 12'h000;
  endtask

  initial begin
    clr_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ld_pte();
    t_st_pte();
    t_pf();
    t_cap();
    t_other();
    t_gated();
    t_nocommit();
    t_csr_miss();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule